// File: doc/BRIEF.md
# ECC Fault Capture Registers

This block sits beside a flash memory controller on a bus fabric that has several masters. The controller sends a one-cycle strobe for each ECC event. One strobe marks a single-bit error that was corrected, and the other marks an error that could not be corrected. With each strobe come the details of the access that caused it: the address, the number of the bus master, that master's attribute byte, and the data word.

A configuration register holds one enable bit for each kind of event. When a strobe arrives and its kind is enabled, the block loads all four access details together and sets the matching status flag. A strobe of a kind that is disabled is dropped. Only the most recent enabled event is kept.

Software reaches the block through a small byte-offset register port. Writes take effect on the clock edge. A read returns its data one cycle after the offset is presented. The capture registers are read-only.

Top module: `ecc_fault_log`

## Requirements
- R1: After synchronous reset, the configuration register (offset 0x43) reads 0 and the status register (offset 0x47) reads 0.
- R2: When `evt_corr` is high and configuration bit 0 is set, the block loads the following in the same clock edge: the address (offset 0x50), the master number (offset 0x56, bits 3:0), the attributes (offset 0x57, bits 7:0) and the data (offset 0x5C). Status bit 0 is set at that edge.
- R3: When `evt_fatal` is high and configuration bit 1 is set, the block loads the same four fields and sets status bit 1.
- R4: A strobe whose enable bit is clear loads no capture field and sets no flag.
- R5: Writes to the offsets 0x50, 0x56, 0x57 and 0x5C change nothing that is read back.
- R6: Bits 31:4 of the master register (offset 0x56) always read 0.
- R7: Writing a 1 to a status bit clears that bit. Writing a 0 leaves the bit unchanged.
- R8: When an enabled event and a clear of its flag fall in the same cycle, the flag ends up set.
- R9: Each enabled event overwrites the earlier capture, even if earlier flags are still set. Flags from earlier events stay set.
- R10: The configuration register keeps bits 1:0 of the write data and reads back 0 in bits 31:2.
- R11: `rd_data` shows the register selected by the `rd_addr` value sampled at the previous clock edge. An offset with no register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_corr | input | 1 | Strobe: a single-bit error was corrected |
| evt_fatal | input | 1 | Strobe: an error could not be corrected |
| evt_addr | input | 32 | Address of the faulting access |
| evt_master | input | 4 | Number of the bus master that made the access |
| evt_attr | input | 8 | Attribute byte of that master |
| evt_data | input | 32 | Data word of the faulting access |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions assume that the controller raises at most one event strobe in any cycle. They also assume that the capture fields hold nothing meaningful until the first enabled event. For that reason, the check that a field stays unchanged is held off until an enabled event has been seen. The bench never raises both strobes together. It reads no capture register before the first enabled event, so the values left undefined by reset are never compared. Reads, writes and events are driven on the falling edge, away from the edge where the block samples them.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;
  localparam int OFF_W = 8;
  localparam int NFLG  = 2;
  // flag / enable bit positions
  localparam int FLG_CORR  = 0;
  localparam int FLG_FATAL = 1;

  localparam logic [OFF_W-1:0] OFF_CFG  = 8'h43;
  localparam logic [OFF_W-1:0] OFF_STAT = 8'h47;
  localparam logic [OFF_W-1:0] OFF_ADDR = 8'h50;
  localparam logic [OFF_W-1:0] OFF_MSTR = 8'h56;
  localparam logic [OFF_W-1:0] OFF_ATTR = 8'h57;
  localparam logic [OFF_W-1:0] OFF_DATA = 8'h5C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_STAT, SEL_ADDR, SEL_MSTR, SEL_ATTR, SEL_DATA
  } rsel_e;

  function automatic rsel_e decode_off(input logic [OFF_W-1:0] off);
    case (off)
      OFF_CFG:  return SEL_CFG;
      OFF_STAT: return SEL_STAT;
      OFF_ADDR: return SEL_ADDR;
      OFF_MSTR: return SEL_MSTR;
      OFF_ATTR: return SEL_ATTR;
      OFF_DATA: return SEL_DATA;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ecc_fault_ctrl.sv
module ecc_fault_ctrl
  import ecc_fault_pkg::*;
#(
  parameter int N = NFLG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic         stat_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] evt,
  output logic [N-1:0] cfg_q,
  output logic [N-1:0] stat_q,
  output logic         cap_en
);
  logic [N-1:0] hit;

  assign hit    = evt & cfg_q;
  assign cap_en = |hit;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= wbits;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      stat_q[i] <= 1'b0;
      else if (hit[i])              stat_q[i] <= 1'b1;   // event beats clear
      else if (stat_we && wbits[i]) stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture #(
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int TW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          cap_en,
  input  logic [AW-1:0] in_addr,
  input  logic [MW-1:0] in_master,
  input  logic [TW-1:0] in_attr,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] cap_addr,
  output logic [MW-1:0] cap_master,
  output logic [TW-1:0] cap_attr,
  output logic [DW-1:0] cap_data
);
  // No reset: contents are undefined until the first enabled event.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      cap_addr   <= in_addr;
      cap_master <= in_master;
      cap_attr   <= in_attr;
      cap_data   <= in_data;
    end
  end
endmodule

// File: rtl/ecc_fault_rdmux.sv
module ecc_fault_rdmux
  import ecc_fault_pkg::*;
#(
  parameter int RW = 32,
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int TW = 8,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] rd_addr,
  input  logic [NFLG-1:0]  cfg_q,
  input  logic [NFLG-1:0]  stat_q,
  input  logic [AW-1:0]    cap_addr,
  input  logic [MW-1:0]    cap_master,
  input  logic [TW-1:0]    cap_attr,
  input  logic [DW-1:0]    cap_data,
  output logic [RW-1:0]    rd_data
);
  logic [RW-1:0] nxt;

  always_comb begin
    nxt = '0;
    case (decode_off(rd_addr))
      SEL_CFG:  nxt[NFLG-1:0] = cfg_q;
      SEL_STAT: nxt[NFLG-1:0] = stat_q;
      SEL_ADDR: nxt[AW-1:0]   = cap_addr;
      SEL_MSTR: nxt[MW-1:0]   = cap_master;
      SEL_ATTR: nxt[TW-1:0]   = cap_attr;
      SEL_DATA: nxt[DW-1:0]   = cap_data;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= nxt;
  end
endmodule

// File: rtl/ecc_fault_log.sv
module ecc_fault_log
  import ecc_fault_pkg::*;
#(
  parameter int RW = 32,
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int TW = 8,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_corr,
  input  logic             evt_fatal,
  input  logic [AW-1:0]    evt_addr,
  input  logic [MW-1:0]    evt_master,
  input  logic [TW-1:0]    evt_attr,
  input  logic [DW-1:0]    evt_data,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_addr,
  input  logic [RW-1:0]    wr_data,
  input  logic [OFF_W-1:0] rd_addr,
  output logic [RW-1:0]    rd_data
);
  logic [NFLG-1:0] evt_vec, cfg_q, stat_q;
  logic            cap_en, cfg_we, stat_we;
  logic [AW-1:0]   cap_addr;
  logic [MW-1:0]   cap_master;
  logic [TW-1:0]   cap_attr;
  logic [DW-1:0]   cap_data;

  assign evt_vec[FLG_CORR]  = evt_corr;
  assign evt_vec[FLG_FATAL] = evt_fatal;
  assign cfg_we  = wr_en && (decode_off(wr_addr) == SEL_CFG);
  assign stat_we = wr_en && (decode_off(wr_addr) == SEL_STAT);

  ecc_fault_ctrl #(.N(NFLG)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .stat_we(stat_we),
    .wbits(wr_data[NFLG-1:0]), .evt(evt_vec),
    .cfg_q(cfg_q), .stat_q(stat_q), .cap_en(cap_en)
  );

  ecc_fault_capture #(.AW(AW), .MW(MW), .TW(TW), .DW(DW)) u_cap (
    .clk(clk), .cap_en(cap_en),
    .in_addr(evt_addr), .in_master(evt_master), .in_attr(evt_attr), .in_data(evt_data),
    .cap_addr(cap_addr), .cap_master(cap_master), .cap_attr(cap_attr), .cap_data(cap_data)
  );

  ecc_fault_rdmux #(.RW(RW), .AW(AW), .MW(MW), .TW(TW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .cfg_q(cfg_q), .stat_q(stat_q),
    .cap_addr(cap_addr), .cap_master(cap_master), .cap_attr(cap_attr), .cap_data(cap_data),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/ecc_fault_log_chk.sv
module ecc_fault_log_chk
  import ecc_fault_pkg::*;
#(
  parameter int RW = 32,
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_corr,
  input logic             evt_fatal,
  input logic             wr_en,
  input logic [OFF_W-1:0] wr_addr,
  input logic [RW-1:0]    wr_data,
  input logic [OFF_W-1:0] rd_addr,
  input logic [RW-1:0]    rd_data,
  input logic [NFLG-1:0]  cfg_q,
  input logic [NFLG-1:0]  stat_q,
  input logic [AW-1:0]    cap_addr
);
  logic en_corr, en_fatal, clr_wr, seen;

  assign en_corr  = evt_corr && cfg_q[FLG_CORR];
  assign en_fatal = evt_fatal && cfg_q[FLG_FATAL];
  assign clr_wr   = wr_en && (wr_addr == OFF_STAT);

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (en_corr || en_fatal) seen <= 1'b1;
  end

  AST_CORR_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    en_corr |=> stat_q[FLG_CORR]); // R2
  AST_FATAL_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    en_fatal |=> stat_q[FLG_FATAL]); // R3
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!en_corr && !en_fatal && !clr_wr) |=> $stable(stat_q)); // R4
  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (seen && !en_corr && !en_fatal) |=> $stable(cap_addr)); // R5
  AST_MASTER_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == OFF_MSTR) |=> (rd_data[RW-1:4] == '0)); // R6
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en_corr && clr_wr && wr_data[FLG_CORR]) |=> stat_q[FLG_CORR]); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (decode_off(rd_addr) == SEL_NONE) |=> (rd_data == '0)); // R11
endmodule

bind ecc_fault_log ecc_fault_log_chk #(.RW(RW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .evt_corr(evt_corr), .evt_fatal(evt_fatal),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data),
  .cfg_q(cfg_q), .stat_q(stat_q), .cap_addr(cap_addr)
);

// File: tb/tb_ecc_fault_log.sv
module tb_ecc_fault_log;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  cfg;
    logic        fatal;
    logic [31:0] a;
    logic [3:0]  m;
    logic [7:0]  at;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 1'b0, 32'h1000_0004, 4'h3, 8'h5A, 32'hDEAD_BEEF},
    '{2'b11, 1'b1, 32'h2000_0010, 4'hF, 8'hA5, 32'h1234_5678},
    '{2'b10, 1'b0, 32'h3000_0020, 4'h1, 8'h11, 32'h0BAD_F00D},
    '{2'b01, 1'b1, 32'h4000_0030, 4'h2, 8'h22, 32'hCAFE_0001},
    '{2'b01, 1'b0, 32'h5000_0040, 4'h7, 8'h77, 32'h7777_0000},
    '{2'b00, 1'b1, 32'h6000_0050, 4'h9, 8'h99, 32'h9999_9999}
  };

  logic        clk = 0, rst = 1;
  logic        evt_corr = 0, evt_fatal = 0, wr_en = 0;
  logic [31:0] evt_addr = 0, evt_data = 0, wr_data = 0;
  logic [3:0]  evt_master = 0;
  logic [7:0]  evt_attr = 0, wr_addr = 0, rd_addr = 8'hFF;
  logic [31:0] rd_data;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_addr, m_data, v;
  logic [3:0]  m_mst;
  logic [7:0]  m_att;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fault_log dut (
    .clk(clk), .rst(rst), .evt_corr(evt_corr), .evt_fatal(evt_fatal),
    .evt_addr(evt_addr), .evt_master(evt_master), .evt_attr(evt_attr), .evt_data(evt_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] val);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #1 val = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic fatal, input logic [31:0] a, input logic [3:0] m,
                       input logic [7:0] at, input logic [31:0] d);
    @(negedge clk);
    evt_corr = !fatal; evt_fatal = fatal;
    evt_addr = a; evt_master = m; evt_attr = at; evt_data = d;
    @(negedge clk); evt_corr = 0; evt_fatal = 0;
  endtask

  task automatic check_capture(input string req);
    rd(8'h50, v); chk({req, " address"}, v, m_addr);
    rd(8'h56, v); chk({req, " master"}, v, {28'h0, m_mst});
    rd(8'h57, v); chk({req, " attributes"}, v, {24'h0, m_att});
    rd(8'h5C, v); chk({req, " data"}, v, m_data);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rd(8'h43, v); chk("R1 config after reset", v, 32'h0);
    rd(8'h47, v); chk("R1 status after reset", v, 32'h0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic en;
      wr(8'h47, 32'h3);
      wr(8'h43, {30'h0, VEC[i].cfg});
      pulse(VEC[i].fatal, VEC[i].a, VEC[i].m, VEC[i].at, VEC[i].d);
      en = VEC[i].cfg[VEC[i].fatal];
      if (en) begin
        m_addr = VEC[i].a; m_mst = VEC[i].m; m_att = VEC[i].at; m_data = VEC[i].d;
      end
      rd(8'h47, v);
      chk(VEC[i].fatal ? "R3 R4 status" : "R2 R4 status", v,
          en ? (VEC[i].fatal ? 32'h2 : 32'h1) : 32'h0);
      check_capture(VEC[i].fatal ? "R3 R4" : "R2 R4");
    end

    // R5 writes to capture registers ignored
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h56, 32'hFF); wr(8'h57, 32'h0); wr(8'h5C, 32'h0);
    check_capture("R5");

    // R6 upper bits of master register
    rd(8'h56, v); chk("R6 master upper bits", {4'h0, v[31:4]}, 32'h0);

    // R9 overwrite with flags pending, both flags kept
    wr(8'h43, 32'h3); wr(8'h47, 32'h3);
    pulse(1'b0, 32'hAAAA_0000, 4'h4, 8'h44, 32'h4444_4444);
    pulse(1'b1, 32'hBBBB_0000, 4'h6, 8'h66, 32'h6666_6666);
    m_addr = 32'hBBBB_0000; m_mst = 4'h6; m_att = 8'h66; m_data = 32'h6666_6666;
    check_capture("R9");
    rd(8'h47, v); chk("R9 both flags", v, 32'h3);

    // R7 write-1-to-clear
    wr(8'h47, 32'h0); rd(8'h47, v); chk("R7 write zero keeps", v, 32'h3);
    wr(8'h47, 32'h1); rd(8'h47, v); chk("R7 clear bit0", v, 32'h2);
    wr(8'h47, 32'h2); rd(8'h47, v); chk("R7 clear bit1", v, 32'h0);

    // R8 event and clear in same cycle
    @(negedge clk);
    evt_corr = 1; evt_addr = 32'hC0C0_C0C0; evt_master = 4'h8; evt_attr = 8'h88; evt_data = 32'h8888_8888;
    wr_en = 1; wr_addr = 8'h47; wr_data = 32'h1;
    @(negedge clk); evt_corr = 0; wr_en = 0;
    rd(8'h47, v); chk("R8 event beats clear", v, 32'h1);

    // R10 config read/write width
    wr(8'h43, 32'hFFFF_FFFE); rd(8'h43, v); chk("R10 config masked", v, 32'h2);
    wr(8'h43, 32'h1);         rd(8'h43, v); chk("R10 config bit0", v, 32'h1);

    // R11 unmapped reads and read latency
    rd(8'h60, v); chk("R11 unmapped", v, 32'h0);
    rd(8'h51, v); chk("R11 unmapped inside block", v, 32'h0);
    @(negedge clk); rd_addr = 8'h43;
    #1 chk("R11 read not yet updated", rd_data, 32'h0);
    @(posedge clk); #1 chk("R11 read one cycle later", rd_data, 32'h1);

    finish_run();
  end
endmodule